// File: doc/BRIEF.md
# Keyed-Clear Watchdog Timer

This block watches over running software. It counts pulses of a slow 32768 Hz time-base enable, sampled in the system clock domain. If software does not service it within 0.75 s (24576 slow ticks), it raises a reset request. Software services it by writing a data word whose two least significant bits are `01`. Any write whose low bits differ is treated as a runaway program, and the reset request is raised at once.

The reset request is a pulse of fixed length in system clocks. The reset network that consumes it is outside this block. Counting depends only on the tick enable, so the watchdog keeps guarding through standby for as long as the slow oscillator runs. A static strap input turns the whole function off.

Top module: `wdt_keyed`

## Requirements
- R1: While and after `rst_ni` is low, `rst_req_o` is 0 and the tick count is zero.
- R2: Each cycle with `tick_i` high advances the count by one. When a valid clear has not been seen since reset or since the last clear, the 24576th tick raises `rst_req_o` in the following clock cycle.
- R3: A write (`wr_i` high) whose `wr_data_i[1:0]` equals `01` returns the count to zero, whatever bits [15:2] hold. The next timeout then needs a further 24576 ticks.
- R4: A write whose `wr_data_i[1:0]` is `00`, `10` or `11` raises `rst_req_o` in the following clock cycle.
- R5: `rst_req_o` stays high for exactly 16 system clocks and then falls. While it is high, writes and ticks have no effect and the pulse is not lengthened. Counting then resumes from zero.
- R6: While `disable_i` is high, `rst_req_o` stays 0 under any writes and any number of ticks.
- R7: Cycles without `tick_i` leave the count unchanged, so a count held near the limit still expires on the next tick.
- R8: A valid clear in the same cycle as the expiring tick wins: no reset request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle enable per 32768 Hz period |
| wr_i | input | 1 | Write strobe to the clear register |
| wr_data_i | input | 16 | Write data; bits [1:0] carry the key |
| disable_i | input | 1 | Static strap; high removes the watchdog |
| rst_req_o | output | 1 | Reset request pulse |

## Verification
The assertions assume that `disable_i` changes only while reset is held, as a strap does, and that `tick_i` and `wr_i` are synchronous single-cycle qualifiers. The pulse assertions also assume a pulse length of at least two clocks. The stimulus changes the strap only inside a reset window, and it drives every input at the falling clock edge. A behavioural model built from integers predicts `rst_req_o` on every cycle. The ticks arrive every cycle during the long runs, so that a full timeout fits in a short run. Idle windows with no ticks cover the hold behaviour.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned KEY_W  = 2;
  localparam logic [KEY_W-1:0] KEY_SERVICE = 2'b01;
endpackage

// File: rtl/wdt_key_decode.sv
module wdt_key_decode
  import wdt_pkg::*;
(
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              key_ok_o,
  output logic              key_bad_o
);
  logic match;
  assign match     = (wr_data_i[KEY_W-1:0] == KEY_SERVICE);
  assign key_ok_o  = wr_i & match;
  assign key_bad_o = wr_i & ~match;
endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
  parameter int unsigned TIMEOUT_TICKS = 24576,
  localparam int unsigned CW = $clog2(TIMEOUT_TICKS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          clr_i,
  output logic          expire_o,
  output logic [CW-1:0] count_o
);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_TICKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = tick_i & (cnt_q == LAST);
  assign count_o  = cnt_q;

  // R2: one tick, one step
  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !clr_i && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R7: no tick, no change
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_rst_stretch.sv
module wdt_rst_stretch #(
  parameter int unsigned PULSE_CYCLES = 16,
  localparam int unsigned PW = $clog2(PULSE_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic req_o
);
  logic [PW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     left_q <= '0;
    else if (fire_i && left_q == '0) left_q <= PW'(PULSE_CYCLES);
    else if (left_q != '0)           left_q <= left_q - 1'b1;
  end

  assign req_o = (left_q != '0);

  // R5: a request only starts from a fire event
  a_r5_rise_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(fire_i));

  generate
    if (PULSE_CYCLES > 1) begin : g_multi
      a_r5_no_glitch: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(req_o) |=> req_o);
    end
  endgenerate
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_pkg::*;
#(
  parameter int unsigned TIMEOUT_TICKS = 24576,
  parameter int unsigned PULSE_CYCLES  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              disable_i,
  output logic              rst_req_o
);
  localparam int unsigned CW = $clog2(TIMEOUT_TICKS);

  logic          key_ok, key_bad, expire, run, fire, clr;
  logic [CW-1:0] count;

  wdt_key_decode u_key (
    .wr_i      (wr_i),
    .wr_data_i (wr_data_i),
    .key_ok_o  (key_ok),
    .key_bad_o (key_bad)
  );

  // counting is frozen while disabled or while a request is out
  assign run  = ~disable_i & ~rst_req_o;
  assign fire = run & (key_bad | (expire & ~key_ok));
  assign clr  = ~run | key_ok | fire;

  wdt_tick_counter #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .clr_i    (clr),
    .expire_o (expire),
    .count_o  (count)
  );

  wdt_rst_stretch #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire),
    .req_o  (rst_req_o)
  );

  a_r3_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wr_data_i[KEY_W-1:0] == KEY_SERVICE && !disable_i && !rst_req_o)
    |=> (count == '0));
  a_r4_bad_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wr_data_i[KEY_W-1:0] != KEY_SERVICE && !disable_i && !rst_req_o)
    |=> rst_req_o);
  a_r6_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disable_i && !rst_req_o) |=> !rst_req_o);
  a_r8_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && count == CW'(TIMEOUT_TICKS - 1) && wr_i &&
     wr_data_i[KEY_W-1:0] == KEY_SERVICE && !disable_i && !rst_req_o)
    |=> !rst_req_o);
endmodule

// File: tb/sim_wdt_keyed.sv
`timescale 1ns/1ps
module sim_wdt_keyed;
  localparam int T = 24576;
  localparam int P = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, wr = 1'b0, dis = 1'b0;
  logic [15:0] wdata = '0;
  logic req;

  int checks = 0, errors = 0, cycles = 0;
  int m_cnt = 0, m_pulse = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  wdt_keyed u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_i(wr),
    .wr_data_i(wdata), .disable_i(dis), .rst_req_o(req)
  );

  task automatic chk(input string t, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s rst_req_o=%b expected=%b at cycle %0d", t, got, exp, cycles);
    end
  endtask

  // one clock: drive at falling edge, update model, compare at next falling edge
  task automatic step(input logic tk, input logic w, input logic [15:0] d);
    bit ok, fire;
    tick = tk; wr = w; wdata = d;
    @(posedge clk);
    ok   = w && d[1:0] == 2'b01;
    fire = !dis && m_pulse == 0 &&
           ((w && !ok) || (!ok && tk && m_cnt == T - 1));
    if (dis || m_pulse != 0 || ok || fire) m_cnt = 0;
    else if (tk) m_cnt++;
    if (fire) m_pulse = P;
    else if (m_pulse > 0) m_pulse--;
    @(negedge clk);
    cycles++;
    chk(tag, req, m_pulse > 0);
    tick = 1'b0; wr = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 16'h0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 16'h0);
  endtask

  task automatic do_reset(input logic strap);
    rst_n = 1'b0; dis = strap;
    m_cnt = 0; m_pulse = 0;
    repeat (3) @(negedge clk);
    chk("R1", req, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", req, 1'b0);
  endtask

  // count high cycles of a pulse that is already up
  task automatic pulse_len(input string t);
    int n = 1;
    while (req === 1'b1 && n < 100) begin
      step(1'b1, 1'b0, 16'h0);
      if (req === 1'b1) n++;
    end
    checks++;
    if (n != P) begin
      errors++;
      $display("FAIL %s pulse length=%0d expected=%0d", t, n, P);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, tag %s", tag);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset(1'b0);

    // R2: timeout from reset
    tag = "R2";
    run_ticks(T - 1);
    chk("R2", req, 1'b0);
    step(1'b1, 1'b0, 16'h0);
    chk("R2", req, 1'b1);
    tag = "R5";
    pulse_len("R5");
    chk("R5", req, 1'b0);

    // R3: valid key with upper bits set restarts the window
    tag = "R3";
    run_ticks(10000);
    step(1'b1, 1'b1, 16'hFFFD);
    run_ticks(T - 1);
    chk("R3", req, 1'b0);
    step(1'b1, 1'b0, 16'h0);
    chk("R3", req, 1'b1);
    tag = "R5";
    // R5: writes inside the pulse neither extend nor retrigger it
    step(1'b1, 1'b1, 16'h0002);
    step(1'b1, 1'b1, 16'h0001);
    chk("R5", req, 1'b1);
    idle(P - 3);
    chk("R5", req, 1'b1);
    idle(1);
    chk("R5", req, 1'b0);

    // R8: clear coincident with the expiring tick
    tag = "R8";
    run_ticks(T - 1);
    step(1'b1, 1'b1, 16'h8001);
    chk("R8", req, 1'b0);
    idle(3);
    chk("R8", req, 1'b0);

    // R4: each wrong key pattern
    tag = "R4";
    for (int k = 0; k < 4; k++) begin
      if (k == 1) continue;
      step(1'b0, 1'b1, 16'h1230 | 16'(k));
      chk("R4", req, 1'b1);
      pulse_len("R4");
      idle(4);
    end

    // R7: hold near the limit without ticks
    tag = "R7";
    run_ticks(T - 1);
    idle(5000);
    chk("R7", req, 1'b0);
    step(1'b1, 1'b0, 16'h0);
    chk("R7", req, 1'b1);
    idle(P + 2);
    chk("R7", req, 1'b0);

    // R6: strap disables everything
    do_reset(1'b1);
    tag = "R6";
    step(1'b0, 1'b1, 16'h0000);
    chk("R6", req, 1'b0);
    step(1'b0, 1'b1, 16'h0003);
    chk("R6", req, 1'b0);
    run_ticks(T + 100);
    chk("R6", req, 1'b0);

    do_reset(1'b0);
    tag = "R1";
    idle(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule